// File: doc/BRIEF.md
# Full-Map Coherence Directory Controller

This block is the single central point through which every coherence transaction of an eight-processor shared-memory system passes. For each shared memory block it keeps one directory entry. An entry holds a presence vector with one bit per processor cache, a modified flag and a broadcast flag. Local cache controllers send it read-miss and write requests. The controller updates the entry for the addressed block and, when other caches must act, sends one notice naming the target caches, the block and the kind of action.

The request port and the notice port are valid/ready streams. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The controller serves one request at a time. From the acceptance edge until its notice, if any, has been taken, `req_ready` stays low. A notice is taken on an edge where `ntc_valid` and `ntc_ready` are both high. While `ntc_ready` is low the notice is held unchanged, and that back-pressure holds off new requests. Moving data, the interconnect and the cache arrays are handled elsewhere.

The broadcast flag decides where a write's invalidation goes. When it is clear, the invalidation goes only to the recorded sharers. When it is set, it goes to every processor other than the writer.

Top module: `fullmap_dir_ctrl`

## Requirements
- R1: After reset every entry is clean, has the broadcast flag clear and has an empty presence vector. `req_ready` is high and `ntc_valid` is low.
- R2: A read miss (op code 0) from processor p on a clean block sets presence bit p and produces no notice.
- R3: A read miss on a modified block produces one write-back notice (kind code 2) whose target vector is the owner's bit. The block then becomes clean, with both the owner and the requester recorded.
- R4: A write (op code 1) on a block with the broadcast flag clear sends one invalidate notice (kind code 1) to every recorded sharer except the writer. If there are no such sharers, no notice is sent.
- R5: After a write the block is modified and the writer is its only recorded holder. A later read miss by another processor therefore produces a write-back notice to exactly the writer's bit.
- R6: Op code 2 sets the broadcast flag of the addressed block and op code 3 clears it. Neither op produces a notice. While the flag is set, a write invalidates every processor except the writer.
- R7: Only one request is in service at a time. `req_ready` is low from the acceptance edge until the notice is taken, and `ntc_valid` is never high while `req_ready` is high.
- R8: While `ntc_valid` is high and `ntc_ready` is low, the target vector, block index and kind stay stable. Every notice names at least one target.
- R9: The notice appears in the cycle after its request is accepted. `req_ready` returns in the cycle after the notice is taken. A request that produces no notice leaves `req_ready` high in the next cycle.
- R10: Entries are independent. A request on one block index never changes the state seen through another index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_pid | input | 3 | Requesting processor number; bit p of a vector is processor p |
| req_blk | input | 4 | Block index |
| req_op | input | 2 | 0 read miss, 1 write, 2 set broadcast, 3 clear broadcast |
| ntc_valid | output | 1 | Notice pending |
| ntc_ready | input | 1 | Notice accepted by the network |
| ntc_targets | output | 8 | Processors that must act |
| ntc_blk | output | 4 | Block the notice concerns |
| ntc_kind | output | 2 | 1 invalidate, 2 write-back |

## Verification
The directory state is visible only through the notices that later requests produce. A wrong presence bit or modified flag therefore shows up at the next request that touches the same block. It can appear as a missing notice, an extra notice, a wrong target vector or a wrong kind, in the cycle after that request is accepted. The tests chain requests on one block so that each step exposes the state left by the step before it. They also probe neighbouring indices to catch entries leaking into one another. A fault in the handshake shows within one cycle as `req_ready` or `ntc_valid` at the wrong level, or as a notice that changes while it is stalled.

// File: rtl/dir_pkg.sv
package dir_pkg;
  parameter int DIR_NPROC_DEF = 8;
  parameter int DIR_NBLK_DEF  = 16;

  typedef enum logic [1:0] {
    OP_RDMISS    = 2'd0,
    OP_WRITE     = 2'd1,
    OP_BCAST_ON  = 2'd2,
    OP_BCAST_OFF = 2'd3
  } dir_op_e;

  typedef enum logic [1:0] {
    NT_NONE  = 2'd0,
    NT_INVAL = 2'd1,
    NT_WBACK = 2'd2
  } notice_e;
endpackage

// File: rtl/dir_entry_store.sv
module dir_entry_store #(
  parameter int NPROC = dir_pkg::DIR_NPROC_DEF,
  parameter int NBLK  = dir_pkg::DIR_NBLK_DEF,
  localparam int BLK_W = $clog2(NBLK),
  localparam int ENT_W = NPROC + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BLK_W-1:0] rd_blk,
  output logic [ENT_W-1:0] rd_entry,
  input  logic             wr_en,
  input  logic [BLK_W-1:0] wr_blk,
  input  logic [ENT_W-1:0] wr_entry
);
  // entry layout: [ENT_W-1] modified, [NPROC] broadcast, [NPROC-1:0] presence
  logic [ENT_W-1:0] entries [NBLK];

  genvar g;
  generate
    for (g = 0; g < NBLK; g++) begin : g_ent
      always_ff @(posedge clk) begin
        if (!rst_n)
          entries[g] <= '0;
        else if (wr_en && (wr_blk == BLK_W'(g)))
          entries[g] <= wr_entry;
      end

      // a modified block has exactly one holder (R5)
      a_r5_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        entries[g][ENT_W-1] |-> $onehot(entries[g][NPROC-1:0]));
    end
  endgenerate

  assign rd_entry = entries[rd_blk];
endmodule

// File: rtl/dir_policy.sv
module dir_policy #(
  parameter int NPROC = dir_pkg::DIR_NPROC_DEF,
  localparam int PID_W = $clog2(NPROC),
  localparam int ENT_W = NPROC + 2
) (
  input  dir_pkg::dir_op_e op,
  input  logic [PID_W-1:0] pid,
  input  logic [ENT_W-1:0] cur,
  output logic [ENT_W-1:0] nxt,
  output logic             send,
  output logic [NPROC-1:0] targets,
  output dir_pkg::notice_e kind
);
  import dir_pkg::*;

  logic             cur_mod;
  logic             cur_bc;
  logic [NPROC-1:0] cur_pres;
  logic [NPROC-1:0] self_bit;
  logic [NPROC-1:0] others;

  assign cur_mod  = cur[ENT_W-1];
  assign cur_bc   = cur[NPROC];
  assign cur_pres = cur[NPROC-1:0];
  assign self_bit = NPROC'(1) << pid;
  assign others   = cur_bc ? ~self_bit : (cur_pres & ~self_bit);

  always_comb begin
    nxt     = cur;
    send    = 1'b0;
    targets = '0;
    kind    = NT_NONE;
    unique case (op)
      OP_RDMISS: begin
        nxt[NPROC-1:0] = cur_pres | self_bit;
        if (cur_mod) begin
          send         = 1'b1;
          targets      = cur_pres;
          kind         = NT_WBACK;
          nxt[ENT_W-1] = 1'b0;
        end
      end
      OP_WRITE: begin
        nxt[ENT_W-1]   = 1'b1;
        nxt[NPROC-1:0] = self_bit;
        if (others != '0) begin
          send    = 1'b1;
          targets = others;
          kind    = NT_INVAL;
        end
      end
      OP_BCAST_ON:  nxt[NPROC] = 1'b1;
      OP_BCAST_OFF: nxt[NPROC] = 1'b0;
      default: ;
    endcase
  end
endmodule

// File: rtl/dir_notice_port.sv
module dir_notice_port #(
  parameter int NPROC = dir_pkg::DIR_NPROC_DEF,
  parameter int NBLK  = dir_pkg::DIR_NBLK_DEF,
  localparam int BLK_W = $clog2(NBLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NPROC-1:0] ld_targets,
  input  logic [BLK_W-1:0] ld_blk,
  input  dir_pkg::notice_e ld_kind,
  output logic             valid,
  input  logic             ready,
  output logic [NPROC-1:0] targets,
  output logic [BLK_W-1:0] blk,
  output logic [1:0]       kind
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      targets <= '0;
      blk     <= '0;
      kind    <= '0;
    end else if (load) begin
      valid   <= 1'b1;
      targets <= ld_targets;
      blk     <= ld_blk;
      kind    <= ld_kind;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(targets) && $stable(blk) && $stable(kind)));

  a_r8_nonempty_targets: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (targets != '0));
endmodule

// File: rtl/fullmap_dir_ctrl.sv
module fullmap_dir_ctrl #(
  parameter int NPROC = dir_pkg::DIR_NPROC_DEF,
  parameter int NBLK  = dir_pkg::DIR_NBLK_DEF,
  localparam int PID_W = $clog2(NPROC),
  localparam int BLK_W = $clog2(NBLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [PID_W-1:0] req_pid,
  input  logic [BLK_W-1:0] req_blk,
  input  logic [1:0]       req_op,
  output logic             ntc_valid,
  input  logic             ntc_ready,
  output logic [NPROC-1:0] ntc_targets,
  output logic [BLK_W-1:0] ntc_blk,
  output logic [1:0]       ntc_kind
);
  import dir_pkg::*;
  localparam int ENT_W = NPROC + 2;

  typedef enum logic {ST_IDLE, ST_SEND} ctrl_st_e;
  ctrl_st_e st;

  logic             accept;
  logic [ENT_W-1:0] cur_entry;
  logic [ENT_W-1:0] nxt_entry;
  logic             pol_send;
  logic [NPROC-1:0] pol_targets;
  notice_e          pol_kind;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;

  dir_entry_store #(.NPROC(NPROC), .NBLK(NBLK)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_blk   (req_blk),
    .rd_entry (cur_entry),
    .wr_en    (accept),
    .wr_blk   (req_blk),
    .wr_entry (nxt_entry)
  );

  dir_policy #(.NPROC(NPROC)) u_policy (
    .op      (dir_op_e'(req_op)),
    .pid     (req_pid),
    .cur     (cur_entry),
    .nxt     (nxt_entry),
    .send    (pol_send),
    .targets (pol_targets),
    .kind    (pol_kind)
  );

  dir_notice_port #(.NPROC(NPROC), .NBLK(NBLK)) u_notice (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept && pol_send),
    .ld_targets (pol_targets),
    .ld_blk     (req_blk),
    .ld_kind    (pol_kind),
    .valid      (ntc_valid),
    .ready      (ntc_ready),
    .targets    (ntc_targets),
    .blk        (ntc_blk),
    .kind       (ntc_kind)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      st <= ST_IDLE;
    else if (st == ST_IDLE) begin
      if (accept && pol_send) st <= ST_SEND;
    end else if (ntc_valid && ntc_ready)
      st <= ST_IDLE;
  end

  a_r7_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    !(ntc_valid && req_ready));

  a_r9_notice_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pol_send) |=> (ntc_valid && !req_ready));

  a_r9_ready_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (ntc_valid && ntc_ready) |=> req_ready);
endmodule

// File: tb/fullmap_dir_ctrl_bench.sv
module fullmap_dir_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [2:0] req_pid = '0;
  logic [3:0] req_blk = '0;
  logic [1:0] req_op = '0;
  logic       ntc_valid;
  logic       ntc_ready = 1'b1;
  logic [7:0] ntc_targets;
  logic [3:0] ntc_blk;
  logic [1:0] ntc_kind;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // bench model of the directory
  logic [7:0] m_pres [16];
  logic       m_mod  [16];
  logic       m_bc   [16];

  always #5 clk = ~clk;

  fullmap_dir_ctrl u_fullmap_dir_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_pid(req_pid), .req_blk(req_blk), .req_op(req_op),
    .ntc_valid(ntc_valid), .ntc_ready(ntc_ready), .ntc_targets(ntc_targets),
    .ntc_blk(ntc_blk), .ntc_kind(ntc_kind));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one request, expected outcome computed from the model
  task automatic run_req(input int pid, input int blk, input int op, input string req);
    logic [7:0] self_b, tg;
    logic       snd;
    logic [1:0] knd;
    self_b = 8'(1) << pid;
    snd = 1'b0; tg = '0; knd = 2'd0;
    case (op)
      0: begin
        if (m_mod[blk]) begin snd = 1'b1; tg = m_pres[blk]; knd = 2'd2; m_mod[blk] = 1'b0; end
        m_pres[blk] = m_pres[blk] | self_b;
      end
      1: begin
        tg = m_bc[blk] ? ~self_b : (m_pres[blk] & ~self_b);
        snd = (tg != 0); knd = 2'd1;
        m_mod[blk] = 1'b1; m_pres[blk] = self_b;
      end
      2: m_bc[blk] = 1'b1;
      default: m_bc[blk] = 1'b0;
    endcase
    @(negedge clk);
    check({req, " ready before request"}, 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_pid = 3'(pid); req_blk = 4'(blk); req_op = 2'(op);
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " notice present"}, 32'(ntc_valid), 32'(snd));
    if (snd) begin
      check({req, " ready low while busy"}, 32'(req_ready), 32'd0);
      check({req, " targets"}, 32'(ntc_targets), 32'(tg));
      check({req, " kind"}, 32'(ntc_kind), 32'(knd));
      check({req, " block"}, 32'(ntc_blk), 32'(blk));
      if (ntc_ready) begin
        @(negedge clk);
        check({req, " ready back"}, 32'(req_ready), 32'd1);
        check({req, " notice gone"}, 32'(ntc_valid), 32'd0);
      end
    end else begin
      check({req, " ready next cycle"}, 32'(req_ready), 32'd1);
    end
  endtask

  task automatic t_reset;
    check("R1 ready after reset", 32'(req_ready), 32'd1);
    check("R1 no notice after reset", 32'(ntc_valid), 32'd0);
    // clean state: a write on a fresh block has nobody to invalidate
    run_req(3, 9, 1, "R1 fresh block write");
  endtask

  task automatic t_sharers;
    run_req(1, 3, 0, "R2 read p1");
    run_req(4, 3, 0, "R2 read p4");
    run_req(0, 3, 1, "R4 write p0 invalidates 1,4");
    run_req(2, 3, 1, "R4 write p2 invalidates owner");
    run_req(5, 3, 0, "R3 read p5 writeback to p2");
    run_req(6, 3, 1, "R4 write p6 invalidates 2,5");
    run_req(6, 3, 1, "R4 rewrite by sole owner no notice");
  endtask

  task automatic t_owner;
    run_req(7, 5, 1, "R5 write p7");
    run_req(0, 5, 0, "R5 read p0 writeback to p7 only");
    run_req(0, 5, 0, "R2 second read clean no notice");
  endtask

  task automatic t_broadcast;
    run_req(0, 7, 2, "R6 set broadcast");
    run_req(1, 7, 0, "R6 read p1");
    run_req(1, 7, 1, "R6 broadcast write all but p1");
    run_req(0, 7, 3, "R6 clear broadcast");
    run_req(3, 7, 0, "R6 read p3");
    run_req(1, 7, 1, "R6 sharer-only write after clear");
  endtask

  task automatic t_backpressure;
    ntc_ready = 1'b0;
    run_req(2, 11, 0, "R7 read p2");
    ntc_ready = 1'b0;
    m_mod[11] = 1'b0;
    run_req(4, 11, 1, "R7 write p4 stalled");
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R7 ready held low", 32'(req_ready), 32'd0);
      check("R8 valid held", 32'(ntc_valid), 32'd1);
      check("R8 targets stable", 32'(ntc_targets), 32'h04);
      check("R8 kind stable", 32'(ntc_kind), 32'd1);
    end
    ntc_ready = 1'b1;
    @(negedge clk);
    check("R9 notice taken", 32'(ntc_valid), 32'd0);
    check("R9 ready returns", 32'(req_ready), 32'd1);
  endtask

  task automatic t_isolation;
    run_req(5, 0, 1, "R10 write blk0");
    run_req(1, 15, 0, "R10 read blk15 unaffected");
    run_req(2, 1, 0, "R10 read blk1 unaffected");
    run_req(2, 0, 0, "R10 blk0 still owned by p5");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin m_pres[i] = '0; m_mod[i] = 1'b0; m_bc[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sharers();
    t_owner();
    t_broadcast();
    t_backpressure();
    t_isolation();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule